// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits next to one multiprocessor. It decides whether a new thread block may become resident there. A request gives the number of threads in the block and the registers each thread uses. In the same cycle the block works out the warp count and register charge, and compares them with three shared limits: the resident-block count, the resident-warp count and the register budget. It then answers with either a grant carrying a slot number or a reject carrying a reason code.

Resident blocks are tracked in a table of slots. When a block finishes, a completion names its slot, and the resources it held are returned to the pool. Because the three limits apply together, the shape of a block sets occupancy. Large register-hungry blocks run out of registers first, small blocks run out of block slots, and wide blocks run out of warps.

Top module: `tblk_admit`

## Requirements
- R1: A request is charged ceil(threads/32) warps and ceil(threads/32)*32*regs_per_thread registers; after a grant, `res_warps` and `res_regs` grow by exactly these amounts at the next clock edge.
- R2: A request with fewer than 64 or more than 512 threads is rejected with `reject_code` = 1, whatever the resource state.
- R3: At most 8 blocks are resident; a request in range that finds 8 resident blocks (after any same-cycle release) is rejected with code 2.
- R4: At most 24 warps are resident; a request whose warps would push the total past 24 is rejected with code 3.
- R5: At most 8192 registers are in use; a request whose charge would push the total past 8192 is rejected with code 4 (for example, 256 threads at 14 registers per thread fit twice but not three times).
- R6: Reject reasons are checked in the fixed order range, blocks, warps, registers, and the first that fails gives the code. `grant` and `reject` are decided combinationally in the request cycle; exactly one of them is high when `req_valid` is high, neither when it is low, and `reject_code` is 0 unless `reject` is high.
- R7: A grant returns in `grant_slot` the lowest-numbered free slot (0..7), and that slot is held until its completion.
- R8: A completion naming an occupied slot frees that slot and removes its blocks, warps and registers from the totals at the next clock edge.
- R9: When a completion and a request arrive in the same cycle, the release is applied first, so the freed slot and resources are available to that request.
- R10: A completion naming a free slot is ignored; `done_err` is high in that cycle and the totals are unchanged.
- R11: After reset all slots are free, the three totals are 0, and no grant or reject is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present this cycle |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 8 | Registers per thread |
| grant | output | 1 | Request admitted |
| grant_slot | output | 3 | Slot assigned on grant, else 0 |
| reject | output | 1 | Request refused |
| reject_code | output | 3 | 0 none, 1 range, 2 blocks, 3 warps, 4 registers |
| done_valid | input | 1 | A resident block has finished |
| done_slot | input | 3 | Slot of the finished block |
| done_err | output | 1 | Completion named a free slot |
| res_blocks | output | 4 | Resident blocks |
| res_warps | output | 5 | Resident warps |
| res_regs | output | 14 | Registers in use |

## Verification
Block sizes are chosen so that each limit in turn is the one that binds. Repeated 256-thread blocks at 14 registers run out of registers after two grants. Blocks of 128 threads at the same register count run out of registers after four. Blocks of 96 threads with no registers fill all eight slots while the warp and register totals still fit, and a 512-thread block followed by another shows the warp limit on its own. Out-of-range sizes sent while the pool is full tell the priority of the range check apart from the resource checks. A completion paired with a request in the same cycle shows whether the release is counted before the check. Releases of single slots show that the lowest free slot is reused, and completions to free slots show that they change nothing.

// File: rtl/tblk_admit_pkg.sv
`timescale 1ns/1ps
package tblk_admit_pkg;

  typedef enum logic [2:0] {
    RJ_NONE   = 3'd0,
    RJ_RANGE  = 3'd1,
    RJ_BLOCKS = 3'd2,
    RJ_WARPS  = 3'd3,
    RJ_REGS   = 3'd4
  } rej_e;

  // integer ceiling division used for the warp count
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // register charge of a block: whole warps times lanes times per-thread registers
  function automatic int unsigned reg_charge(input int unsigned warps,
                                             input int unsigned lanes,
                                             input int unsigned per_thread);
    return warps * lanes * per_thread;
  endfunction

  // true when adding need to used stays within limit
  function automatic logic fits(input int unsigned used, input int unsigned need,
                                input int unsigned limit);
    return (used + need) <= limit;
  endfunction

endpackage

// File: rtl/tblk_cost.sv
`timescale 1ns/1ps
module tblk_cost
  import tblk_admit_pkg::*;
#(
  parameter int WARP_THREADS = 32,
  parameter int MIN_THREADS  = 64,
  parameter int MAX_THREADS  = 512,
  parameter int THR_W        = 10,
  parameter int RPT_W        = 8,
  parameter int WPB_W        = 5,
  parameter int CHG_W        = 17
) (
  input  logic [THR_W-1:0] threads,
  input  logic [RPT_W-1:0] regs_per_thr,
  output logic             in_range,
  output logic [WPB_W-1:0] warps_need,
  output logic [CHG_W-1:0] regs_need
);
  int unsigned thr_u;
  int unsigned warps_u;
  int unsigned regs_u;

  always_comb begin
    thr_u      = int'(threads);
    in_range   = (thr_u >= MIN_THREADS) && (thr_u <= MAX_THREADS);
    warps_u    = ceil_div(thr_u, WARP_THREADS);
    regs_u     = reg_charge(warps_u, WARP_THREADS, int'(regs_per_thr));
    warps_need = WPB_W'(warps_u);
    regs_need  = CHG_W'(regs_u);
  end
endmodule

// File: rtl/tblk_slots.sv
`timescale 1ns/1ps
module tblk_slots #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int WPB_W     = 5,
  parameter int REG_W     = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_valid,
  input  logic [SLOT_W-1:0]    done_slot,
  input  logic                 alloc_en,
  input  logic [SLOT_W-1:0]    alloc_slot,
  input  logic [WPB_W-1:0]     alloc_warps,
  input  logic [REG_W-1:0]     alloc_regs,
  output logic [NUM_SLOTS-1:0] occ,
  output logic                 rel_ok,
  output logic [WPB_W-1:0]     rel_warps,
  output logic [REG_W-1:0]     rel_regs,
  output logic                 free_any,
  output logic [SLOT_W-1:0]    free_slot
);
  logic [WPB_W-1:0]     slot_warps [NUM_SLOTS];
  logic [REG_W-1:0]     slot_regs  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] rel_mask;
  logic [NUM_SLOTS-1:0] avail;
  logic                 idx_ok;

  assign idx_ok = int'(done_slot) < NUM_SLOTS;

  always_comb begin
    rel_ok    = 1'b0;
    rel_warps = '0;
    rel_regs  = '0;
    rel_mask  = '0;
    if (done_valid && idx_ok && occ[done_slot]) begin
      rel_ok              = 1'b1;
      rel_warps           = slot_warps[done_slot];
      rel_regs            = slot_regs[done_slot];
      rel_mask[done_slot] = 1'b1;
    end
  end

  // a slot being released this cycle counts as free for the request
  assign avail    = ~(occ & ~rel_mask);
  assign free_any = |avail;

  always_comb begin
    free_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) free_slot = SLOT_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[g]        <= 1'b0;
        slot_warps[g] <= '0;
        slot_regs[g]  <= '0;
      end else if (alloc_en && alloc_slot == SLOT_W'(g)) begin
        occ[g]        <= 1'b1;
        slot_warps[g] <= alloc_warps;
        slot_regs[g]  <= alloc_regs;
      end else if (rel_mask[g]) begin
        occ[g]        <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tblk_usage.sv
`timescale 1ns/1ps
module tblk_usage #(
  parameter int B_W   = 4,
  parameter int W_W   = 5,
  parameter int WPB_W = 5,
  parameter int REG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_ok,
  input  logic [WPB_W-1:0] rel_warps,
  input  logic [REG_W-1:0] rel_regs,
  input  logic             adm,
  input  logic [WPB_W-1:0] adm_warps,
  input  logic [REG_W-1:0] adm_regs,
  output logic [B_W-1:0]   blocks,
  output logic [W_W-1:0]   warps,
  output logic [REG_W-1:0] regs,
  output logic [B_W-1:0]   blocks_eff,
  output logic [W_W-1:0]   warps_eff,
  output logic [REG_W-1:0] regs_eff
);
  // totals after the same-cycle release, seen by the admission check
  always_comb begin
    blocks_eff = blocks;
    warps_eff  = warps;
    regs_eff   = regs;
    if (rel_ok) begin
      blocks_eff = blocks - B_W'(1);
      warps_eff  = warps - W_W'(rel_warps);
      regs_eff   = regs - rel_regs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocks <= '0;
      warps  <= '0;
      regs   <= '0;
    end else if (adm) begin
      blocks <= blocks_eff + B_W'(1);
      warps  <= warps_eff + W_W'(adm_warps);
      regs   <= regs_eff + adm_regs;
    end else begin
      blocks <= blocks_eff;
      warps  <= warps_eff;
      regs   <= regs_eff;
    end
  end
endmodule

// File: rtl/tblk_decide.sv
`timescale 1ns/1ps
module tblk_decide
  import tblk_admit_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int MAX_WARPS  = 24,
  parameter int REG_BUDGET = 8192,
  parameter int B_W        = 4,
  parameter int W_W        = 5,
  parameter int WPB_W      = 5,
  parameter int REG_W      = 14,
  parameter int CHG_W      = 17
) (
  input  logic             in_range,
  input  logic [B_W-1:0]   blocks_eff,
  input  logic [W_W-1:0]   warps_eff,
  input  logic [REG_W-1:0] regs_eff,
  input  logic [WPB_W-1:0] warps_need,
  input  logic [CHG_W-1:0] regs_need,
  output logic             ok,
  output rej_e             code
);
  logic blk_fit, wrp_fit, reg_fit;

  always_comb begin
    blk_fit = fits(int'(blocks_eff), 1, NUM_SLOTS);
    wrp_fit = fits(int'(warps_eff), int'(warps_need), MAX_WARPS);
    reg_fit = fits(int'(regs_eff), int'(regs_need), REG_BUDGET);
    // fixed priority: range, blocks, warps, registers
    if (!in_range)     code = RJ_RANGE;
    else if (!blk_fit) code = RJ_BLOCKS;
    else if (!wrp_fit) code = RJ_WARPS;
    else if (!reg_fit) code = RJ_REGS;
    else               code = RJ_NONE;
    ok = (code == RJ_NONE);
  end
endmodule

// File: rtl/tblk_admit.sv
`timescale 1ns/1ps
module tblk_admit
  import tblk_admit_pkg::*;
#(
  parameter int NUM_SLOTS    = 8,
  parameter int MAX_WARPS    = 24,
  parameter int REG_BUDGET   = 8192,
  parameter int WARP_THREADS = 32,
  parameter int MIN_THREADS  = 64,
  parameter int MAX_THREADS  = 512,
  parameter int THR_W        = 10,
  parameter int RPT_W        = 8,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int B_W    = $clog2(NUM_SLOTS + 1),
  localparam int W_W    = $clog2(MAX_WARPS + 1),
  localparam int REG_W  = $clog2(REG_BUDGET + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_regs,
  output logic              grant,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              reject,
  output logic [2:0]        reject_code,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  output logic              done_err,
  output logic [B_W-1:0]    res_blocks,
  output logic [W_W-1:0]    res_warps,
  output logic [REG_W-1:0]  res_regs
);
  localparam int WPB_MAX = (MAX_THREADS + WARP_THREADS - 1) / WARP_THREADS;
  localparam int WPB_W   = $clog2(WPB_MAX + 1);
  localparam int CHG_W   = $clog2(WPB_MAX * WARP_THREADS * ((1 << RPT_W) - 1) + 1);

  // named internal events, observed by the bound checker
  logic                 in_range;
  logic [WPB_W-1:0]     warps_need;
  logic [CHG_W-1:0]     regs_need;
  logic [NUM_SLOTS-1:0] occ;
  logic                 rel_ok;
  logic [WPB_W-1:0]     rel_warps;
  logic [REG_W-1:0]     rel_regs;
  logic                 free_any;
  logic [SLOT_W-1:0]    free_slot;
  logic [B_W-1:0]       blocks_eff;
  logic [W_W-1:0]       warps_eff;
  logic [REG_W-1:0]     regs_eff;
  logic                 fit_ok;
  rej_e                 fit_code;
  logic                 adm_fire;

  tblk_cost #(
    .WARP_THREADS(WARP_THREADS), .MIN_THREADS(MIN_THREADS), .MAX_THREADS(MAX_THREADS),
    .THR_W(THR_W), .RPT_W(RPT_W), .WPB_W(WPB_W), .CHG_W(CHG_W)
  ) u_cost (
    .threads(req_threads), .regs_per_thr(req_regs),
    .in_range(in_range), .warps_need(warps_need), .regs_need(regs_need)
  );

  tblk_slots #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WPB_W(WPB_W), .REG_W(REG_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .done_valid(done_valid), .done_slot(done_slot),
    .alloc_en(adm_fire), .alloc_slot(free_slot),
    .alloc_warps(warps_need), .alloc_regs(REG_W'(regs_need)),
    .occ(occ), .rel_ok(rel_ok), .rel_warps(rel_warps), .rel_regs(rel_regs),
    .free_any(free_any), .free_slot(free_slot)
  );

  tblk_usage #(
    .B_W(B_W), .W_W(W_W), .WPB_W(WPB_W), .REG_W(REG_W)
  ) u_usage (
    .clk(clk), .rst_n(rst_n),
    .rel_ok(rel_ok), .rel_warps(rel_warps), .rel_regs(rel_regs),
    .adm(adm_fire), .adm_warps(warps_need), .adm_regs(REG_W'(regs_need)),
    .blocks(res_blocks), .warps(res_warps), .regs(res_regs),
    .blocks_eff(blocks_eff), .warps_eff(warps_eff), .regs_eff(regs_eff)
  );

  tblk_decide #(
    .NUM_SLOTS(NUM_SLOTS), .MAX_WARPS(MAX_WARPS), .REG_BUDGET(REG_BUDGET),
    .B_W(B_W), .W_W(W_W), .WPB_W(WPB_W), .REG_W(REG_W), .CHG_W(CHG_W)
  ) u_decide (
    .in_range(in_range), .blocks_eff(blocks_eff), .warps_eff(warps_eff),
    .regs_eff(regs_eff), .warps_need(warps_need), .regs_need(regs_need),
    .ok(fit_ok), .code(fit_code)
  );

  // block count and slot table agree, so fit_ok implies a free slot exists
  assign adm_fire    = req_valid && fit_ok && free_any;
  assign grant       = adm_fire;
  assign grant_slot  = adm_fire ? free_slot : '0;
  assign reject      = req_valid && !adm_fire;
  assign reject_code = reject ? ((fit_code == RJ_NONE) ? 3'(RJ_BLOCKS) : 3'(fit_code)) : 3'd0;
  assign done_err    = done_valid && !rel_ok;
endmodule

// File: rtl/tblk_admit_chk.sv
`timescale 1ns/1ps
module tblk_admit_chk #(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_WARPS   = 24,
  parameter int REG_BUDGET  = 8192,
  parameter int MIN_THREADS = 64,
  parameter int MAX_THREADS = 512,
  parameter int THR_W       = 10,
  parameter int SLOT_W      = 3,
  parameter int B_W         = 4,
  parameter int W_W         = 5,
  parameter int REG_W       = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [THR_W-1:0]     req_threads,
  input logic                 grant,
  input logic [SLOT_W-1:0]    grant_slot,
  input logic                 reject,
  input logic [2:0]           reject_code,
  input logic                 done_valid,
  input logic [SLOT_W-1:0]    done_slot,
  input logic                 done_err,
  input logic                 rel_ok,
  input logic [NUM_SLOTS-1:0] occ,
  input logic [B_W-1:0]       res_blocks,
  input logic [W_W-1:0]       res_warps,
  input logic [REG_W-1:0]     res_regs
);
  assert_range_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (int'(req_threads) < MIN_THREADS || int'(req_threads) > MAX_THREADS)
      |-> reject && reject_code == 3'd1);

  assert_block_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res_blocks) <= NUM_SLOTS && int'(res_blocks) == $countones(occ));

  assert_warp_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res_warps) <= MAX_WARPS);

  assert_reg_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(res_regs) <= REG_BUDGET);

  assert_one_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({grant, reject}) == 1);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !grant && !reject);

  assert_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !occ[grant_slot] || (rel_ok && done_slot == grant_slot));

  assert_slot_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> occ[$past(grant_slot)]);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok && !grant |=> int'(res_blocks) == int'($past(res_blocks)) - 1);

  assert_bad_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_err && !grant |=> $stable(res_blocks) && $stable(res_warps) && $stable(res_regs));

  assert_err_only_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && occ[done_slot] |-> !done_err);
endmodule

bind tblk_admit tblk_admit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MAX_WARPS(MAX_WARPS), .REG_BUDGET(REG_BUDGET),
  .MIN_THREADS(MIN_THREADS), .MAX_THREADS(MAX_THREADS), .THR_W(THR_W),
  .SLOT_W(SLOT_W), .B_W(B_W), .W_W(W_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
  .grant(grant), .grant_slot(grant_slot), .reject(reject), .reject_code(reject_code),
  .done_valid(done_valid), .done_slot(done_slot), .done_err(done_err),
  .rel_ok(rel_ok), .occ(occ), .res_blocks(res_blocks), .res_warps(res_warps),
  .res_regs(res_regs)
);

// File: tb/sim_tblk_admit.sv
`timescale 1ns/1ps
module sim_tblk_admit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [9:0] req_threads = '0;
  logic [7:0] req_regs = '0;
  logic       grant, reject, done_err;
  logic [2:0] grant_slot, reject_code;
  logic       done_valid = 1'b0;
  logic [2:0] done_slot = '0;
  logic [3:0] res_blocks;
  logic [4:0] res_warps;
  logic [13:0] res_regs;

  always #10 clk = ~clk;  // 50 MHz

  tblk_admit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_regs(req_regs), .grant(grant), .grant_slot(grant_slot), .reject(reject),
    .reject_code(reject_code), .done_valid(done_valid), .done_slot(done_slot),
    .done_err(done_err), .res_blocks(res_blocks), .res_warps(res_warps),
    .res_regs(res_regs)
  );

  typedef struct {
    bit    has_req;
    bit    g;
    int    slot;
    int    code;
    bit    err;
    string tag;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;

  bit m_occ [8];
  int m_w   [8];
  int m_r   [8];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_status(input string tag);
    int b = 0, w = 0, r = 0;
    for (int i = 0; i < 8; i++) if (m_occ[i]) begin b++; w += m_w[i]; r += m_r[i]; end
    chk(tag, "res_blocks", int'(res_blocks), b);
    chk(tag, "res_warps", int'(res_warps), w);
    chk(tag, "res_regs", int'(res_regs), r);
  endtask

  // driver: drives one cycle, pushes the expected answer, then advances the model
  task automatic step(input bit rv, input int thr, input int rpt,
                      input bit dv, input int ds, input string tag);
    item_t it;
    bit eo [8];
    int b = 0, w = 0, r = 0, nw, nr, slot = 0;
    @(negedge clk);
    check_status(tag);
    eo = m_occ;
    it.err = 1'b0;
    if (dv) begin
      if (m_occ[ds]) eo[ds] = 1'b0;
      else it.err = 1'b1;
    end
    for (int i = 0; i < 8; i++) if (eo[i]) begin b++; w += m_w[i]; r += m_r[i]; end
    for (int i = 7; i >= 0; i--) if (!eo[i]) slot = i;
    nw = (thr + 31) / 32;
    nr = nw * 32 * rpt;
    if (thr < 64 || thr > 512) it.code = 1;
    else if (b >= 8)           it.code = 2;
    else if (w + nw > 24)      it.code = 3;
    else if (r + nr > 8192)    it.code = 4;
    else                       it.code = 0;
    it.has_req = rv;
    it.g       = rv && (it.code == 0);
    if (!rv) it.code = 0;
    it.slot = it.g ? slot : 0;
    it.tag  = tag;
    req_valid   = rv;
    req_threads = 10'(thr);
    req_regs    = 8'(rpt);
    done_valid  = dv;
    done_slot   = 3'(ds);
    q.push_back(it);
    @(posedge clk);
    #1;
    m_occ = eo;
    if (it.g) begin
      m_occ[slot] = 1'b1;
      m_w[slot]   = nw;
      m_r[slot]   = nr;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, 0, 1'b0, 0, tag);
  endtask

  task automatic release_all(input string tag);
    for (int i = 0; i < 8; i++) if (m_occ[i]) step(1'b0, 0, 0, 1'b1, i, tag);
  endtask

  // monitor: compares what the design answers with the queued expectation
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "grant", int'(grant), int'(it.g));
        chk(it.tag, "reject", int'(reject), int'(it.has_req && !it.g));
        chk(it.tag, "reject_code", int'(reject_code), it.code);
        chk(it.tag, "grant_slot", int'(grant_slot), it.slot);
        chk(it.tag, "done_err", int'(done_err), int'(it.err));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R11");
    // R2: out-of-range sizes, below and above
    step(1'b1, 63, 4, 1'b0, 0, "R2");
    step(1'b1, 513, 0, 1'b0, 0, "R2");
    // R5: 256 threads x 14 regs fits twice, third hits the register budget
    step(1'b1, 256, 14, 1'b0, 0, "R1");
    step(1'b1, 256, 14, 1'b0, 0, "R7");
    step(1'b1, 256, 14, 1'b0, 0, "R5");
    // R9: release slot 0 and request in the same cycle
    step(1'b1, 256, 14, 1'b1, 0, "R9");
    idle("R9");
    // R10: completion to a free slot
    step(1'b0, 0, 0, 1'b1, 5, "R10");
    idle("R10");
    release_all("R8");
    idle("R8");
    // R5: 128 threads x 14 regs fits four times
    for (int k = 0; k < 5; k++) step(1'b1, 128, 14, 1'b0, 0, "R5");
    release_all("R8");
    // R3: 96 threads (3 warps), no registers: 8 slots fill, ninth rejected
    for (int k = 0; k < 9; k++) step(1'b1, 96, 0, 1'b0, 0, "R3");
    // R6: out-of-range while full still reports range
    step(1'b1, 40, 0, 1'b0, 0, "R6");
    // R7: free slot 3 and slot 1, next grants reuse 1 then 3
    step(1'b0, 0, 0, 1'b1, 3, "R8");
    step(1'b0, 0, 0, 1'b1, 1, "R8");
    step(1'b1, 64, 0, 1'b0, 0, "R7");
    step(1'b1, 64, 0, 1'b0, 0, "R7");
    release_all("R8");
    // R4: 512 threads uses 16 warps, a second one exceeds 24
    step(1'b1, 512, 0, 1'b0, 0, "R4");
    step(1'b1, 512, 0, 1'b0, 0, "R4");
    step(1'b1, 256, 1, 1'b0, 0, "R4");
    step(1'b1, 64, 2, 1'b0, 0, "R4");
    release_all("R8");
    // R1: rounding up of a partial warp (65 threads -> 3 warps, 960 regs)
    step(1'b1, 65, 10, 1'b0, 0, "R1");
    step(1'b1, 100, 255, 1'b0, 0, "R1");
    idle("R1");
    release_all("R8");
    idle("R11");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule